// File: doc/BRIEF.md
# Three-Phase PWM Carrier Engine

This block drives the six gate signals of a three-phase bridge. A programmable carrier counter runs in one of three shapes: a rising sawtooth, a falling sawtooth or a symmetric triangle. Each phase compares the count against its own duty value to form a high-side request, and the low side takes the complement. A per-phase dead-time stage delays every turn-on edge, so the two switches of a leg never conduct together.

The block has two protection paths. A pulse on either over-current comparator flag turns all six gates off. They stay off until the next carrier period begins. A hall-sensor error turns them off only while the error is present. The carrier also emits one-cycle strobes at its top and bottom turning points, which an ADC sequencer can use as sample triggers.

Software programs the block through a byte-wide write port. Period and duty writes go into shadow registers and reach the active copies only at a period start. Mode, prescaler and dead time take effect at once.

Top module: `pwm3_engine`

## Requirements
- R1: While rst_n is low, all six gate outputs and both strobes are low. After reset, with every duty at its default of 0, the three low sides are on and the three high sides are off.
- R2: Carrier mode field value 0 (address 0, bits [1:0]) counts up from 0 to the period P, then wraps to 0. One period is P+1 counter ticks. The peak and valley strobes pulse together in the cycle after the wrap edge.
- R3: Mode value 1 counts down from P to 0, then reloads P. One period is P+1 ticks, and both strobes pulse together at the reload.
- R4: Mode values 2 and 3 count up 0..P and then back down to 1, so one period is 2P ticks. The peak strobe marks the top and the valley strobe marks the bottom, and the two never pulse in the same cycle. From a valley to the next peak is P ticks.
- R5: The counter advances once every (prescaler+1) clocks. The prescaler is written at address 1.
- R6: The high side of phase p requests on while the count is below that phase's 11-bit duty, and the low side requests the complement. Duty bits [10:3] are written at address 4+2p and bits [2:0] at address 5+2p. The period is written at address 2 (low byte) and address 3 (high byte).
- R7: Every turn-on edge of a gate is delayed by that phase's dead-time count (address 10+p) beyond its undelayed position. Turn-off edges are not delayed, and the high and low gates of a phase are never on together.
- R8: Period and duty writes take effect only at a period start: the wrap in modes 0 and 1, the valley in up-down mode. The current period keeps its old timing and old pulse widths.
- R9: An over-current flag (oc_high or oc_low) sampled high at a rising edge forces all six gates low from that edge on. A flag that is still present at a period start keeps the gates low.
- R10: Once no flag is present, the over-current blanking is released at the next period start. The gates then resume their normal values.
- R11: hall_err sampled high at a rising edge forces all gates low from that edge on. They resume at the first edge that samples hall_err low, with no wait for the carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| oc_high | input | 1 | Current above the upper threshold |
| oc_low | input | 1 | Current below the lower threshold |
| hall_err | input | 1 | Hall sensor code invalid |
| gate_hi | output | 3 | High-side gate drives, one bit per phase |
| gate_lo | output | 3 | Low-side gate drives, one bit per phase |
| peak_stb | output | 1 | One-cycle pulse at the carrier top |
| valley_stb | output | 1 | One-cycle pulse at the carrier bottom |

## Verification
Gate outputs follow the counter one clock later, plus the dead time on turn-on edges. Blanking appears one clock after a protection flag is sampled, and strobes appear one clock after the turning edge. For steady-state pulse widths, the checks count gate cycles over exactly four whole carrier periods. This makes the totals independent of where the window starts. For the cycle-exact cases (blanking onset, release at period start, duty hold within the current period), the bench synchronises on a strobe and then samples at a fixed number of falling edges after it, counted from those latencies. Strobe spacing is measured against a free-running cycle counter.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  typedef enum logic [1:0] {
    CM_UP       = 2'd0,
    CM_DOWN     = 2'd1,
    CM_UPDN     = 2'd2,
    CM_UPDN_ALT = 2'd3
  } carrier_mode_e;

  // Both upper encodings select the symmetric triangle.
  function automatic logic f_is_centered(input carrier_mode_e m);
    return (m == CM_UPDN) || (m == CM_UPDN_ALT);
  endfunction

endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int PHASES   = 3,
  parameter int CNT_W    = 16,
  parameter int DUTY_W   = 11,
  parameter int DUTY_LO_W = 3,
  parameter int DT_W     = 8,
  parameter int PRE_W    = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              period_start,
  output carrier_mode_e                     mode,
  output logic [PRE_W-1:0]                  presc,
  output logic [CNT_W-1:0]                  shadow_period,
  output logic [CNT_W-1:0]                  act_period,
  output logic [PHASES-1:0][DUTY_W-1:0]     act_duty,
  output logic [PHASES-1:0][DT_W-1:0]       dead
);

  localparam int DUTY_HI_W   = DUTY_W - DUTY_LO_W;
  localparam int A_CTRL      = 0;
  localparam int A_PRESC     = 1;
  localparam int A_PER_LO    = 2;
  localparam int A_PER_HI    = 3;
  localparam int A_DUTY_BASE = 4;
  localparam int A_DEAD_BASE = A_DUTY_BASE + 2 * PHASES;

  logic [DATA_W-1:0] per_lo_q, per_hi_q;

  function automatic logic f_hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= CM_UP;
      presc    <= '0;
      per_lo_q <= '0;
      per_hi_q <= '0;
    end else if (wr_en) begin
      if (f_hit(wr_addr, A_CTRL))   mode     <= carrier_mode_e'(wr_data[1:0]);
      if (f_hit(wr_addr, A_PRESC))  presc    <= PRE_W'(wr_data);
      if (f_hit(wr_addr, A_PER_LO)) per_lo_q <= wr_data;
      if (f_hit(wr_addr, A_PER_HI)) per_hi_q <= wr_data;
    end
  end

  assign shadow_period = CNT_W'({per_hi_q, per_lo_q});

  always_ff @(posedge clk) begin
    if (!rst_n)            act_period <= '0;
    else if (period_start) act_period <= shadow_period;
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    logic [DUTY_HI_W-1:0] sh_hi_q;
    logic [DUTY_LO_W-1:0] sh_lo_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_hi_q <= '0;
        sh_lo_q <= '0;
        dead[g] <= '0;
      end else if (wr_en) begin
        if (f_hit(wr_addr, A_DUTY_BASE + 2 * g))     sh_hi_q <= wr_data[DUTY_HI_W-1:0];
        if (f_hit(wr_addr, A_DUTY_BASE + 2 * g + 1)) sh_lo_q <= wr_data[DUTY_LO_W-1:0];
        if (f_hit(wr_addr, A_DEAD_BASE + g))         dead[g] <= DT_W'(wr_data);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)            act_duty[g] <= '0;
      else if (period_start) act_duty[g] <= {sh_hi_q, sh_lo_q};
    end
  end

  // R8: active period changes only at a period start
  p_period_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(act_period));

endmodule

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  carrier_mode_e    mode,
  input  logic [PRE_W-1:0] presc,
  input  logic [CNT_W-1:0] act_period,
  input  logic [CNT_W-1:0] shadow_period,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             period_start,
  output logic             peak_stb,
  output logic             valley_stb
);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_n;
  logic             dir_down_q, dir_down_n;
  logic             peak_evt, valley_evt;
  logic             centered;

  function automatic logic [CNT_W-1:0] f_step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] f_valley_restart(input logic [CNT_W-1:0] p);
    return (p == '0) ? '0 : CNT_W'(1);
  endfunction

  assign tick     = (pre_q >= presc);
  assign centered = f_is_centered(mode);

  always_ff @(posedge clk) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    cnt_n      = cnt;
    dir_down_n = dir_down_q;
    peak_evt   = 1'b0;
    valley_evt = 1'b0;
    if (tick) begin
      if (centered) begin
        if (!dir_down_q) begin
          if (cnt >= act_period) begin
            peak_evt   = 1'b1;
            dir_down_n = 1'b1;
            cnt_n      = f_step_down(cnt);
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            valley_evt = 1'b1;
            dir_down_n = 1'b0;
            cnt_n      = f_valley_restart(shadow_period);
          end else begin
            cnt_n = cnt - 1'b1;
          end
        end
      end else if (mode == CM_DOWN) begin
        if (cnt == '0) begin
          peak_evt   = 1'b1;
          valley_evt = 1'b1;
          cnt_n      = shadow_period;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end else begin
        if (cnt >= act_period) begin
          peak_evt   = 1'b1;
          valley_evt = 1'b1;
          cnt_n      = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
    end
  end

  assign period_start = centered ? valley_evt : peak_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      dir_down_q <= 1'b0;
      peak_stb   <= 1'b0;
      valley_stb <= 1'b0;
    end else begin
      cnt        <= cnt_n;
      dir_down_q <= dir_down_n;
      peak_stb   <= peak_evt;
      valley_stb <= valley_evt;
    end
  end

  // R2: in up mode a tick at or above the period brings the count back to zero
  p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CM_UP && cnt >= act_period) |=> (cnt == '0));

  // R3: in down mode a tick at zero reloads a count equal to the new active period
  p_down_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CM_DOWN && cnt == '0) |=> (cnt == act_period));

  // R4: triangle turning points never coincide
  p_no_joint_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (centered && $past(centered)) |-> !(peak_stb && valley_stb));

  // R5: without a tick the count holds
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_on,
  input  logic [DT_W-1:0] dead,
  output logic            hi_o,
  output logic            lo_o
);

  logic            raw_q;
  logic [DT_W-1:0] dcnt_q;
  logic            edge_seen;

  assign edge_seen = (raw_on != raw_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      dcnt_q <= '0;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else begin
      raw_q <= raw_on;
      if (edge_seen) begin
        dcnt_q <= dead;
        if (dead == '0) begin
          hi_o <= raw_on;
          lo_o <= !raw_on;
        end else begin
          hi_o <= 1'b0;
          lo_o <= 1'b0;
        end
      end else if (dcnt_q > DT_W'(1)) begin
        dcnt_q <= dcnt_q - 1'b1;
      end else begin
        dcnt_q <= '0;
        hi_o   <= raw_on;
        lo_o   <= !raw_on;
      end
    end
  end

  // R7: the two switches of a leg are never on together
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_o && lo_o));

  // R7: with a non-zero dead time a high-side turn-on follows a cycle with the low side off
  p_hi_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dead) != '0 && $rose(hi_o)) |-> !$past(lo_o));

  p_lo_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dead) != '0 && $rose(lo_o)) |-> !$past(hi_o));

endmodule

// File: rtl/pwm3_engine.sv
module pwm3_engine
  import pwm3_pkg::*;
#(
  parameter int PHASES    = 3,
  parameter int CNT_W     = 16,
  parameter int DUTY_W    = 11,
  parameter int DUTY_LO_W = 3,
  parameter int DT_W      = 8,
  parameter int PRE_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              oc_high,
  input  logic              oc_low,
  input  logic              hall_err,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo,
  output logic              peak_stb,
  output logic              valley_stb
);

  carrier_mode_e                 mode;
  logic [PRE_W-1:0]              presc;
  logic [CNT_W-1:0]              shadow_period, act_period, cnt;
  logic [PHASES-1:0][DUTY_W-1:0] act_duty;
  logic [PHASES-1:0][DT_W-1:0]   dead;
  logic                          tick, period_start;
  logic [PHASES-1:0]             raw_on, db_hi, db_lo;
  logic                          oc_flag, oc_latch_q, hall_q, blank;

  function automatic logic f_high_request(input logic [CNT_W-1:0] c,
                                          input logic [DUTY_W-1:0] d);
    return c < CNT_W'(d);
  endfunction

  pwm3_regs #(
    .PHASES(PHASES), .CNT_W(CNT_W), .DUTY_W(DUTY_W), .DUTY_LO_W(DUTY_LO_W),
    .DT_W(DT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period_start(period_start), .mode(mode), .presc(presc),
    .shadow_period(shadow_period), .act_period(act_period),
    .act_duty(act_duty), .dead(dead)
  );

  pwm3_carrier #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .mode(mode), .presc(presc),
    .act_period(act_period), .shadow_period(shadow_period),
    .cnt(cnt), .tick(tick), .period_start(period_start),
    .peak_stb(peak_stb), .valley_stb(valley_stb)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_leg
    assign raw_on[g] = f_high_request(cnt, act_duty[g]);

    pwm3_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .raw_on(raw_on[g]), .dead(dead[g]),
      .hi_o(db_hi[g]), .lo_o(db_lo[g])
    );
  end

  assign oc_flag = oc_high | oc_low;

  // Set has priority over the period-start clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_latch_q <= 1'b0;
      hall_q     <= 1'b0;
    end else begin
      hall_q <= hall_err;
      if (oc_flag)           oc_latch_q <= 1'b1;
      else if (period_start) oc_latch_q <= 1'b0;
    end
  end

  assign blank   = oc_latch_q | hall_q;
  assign gate_hi = db_hi & {PHASES{~blank}};
  assign gate_lo = db_lo & {PHASES{~blank}};

  // R9: a sampled over-current flag turns every gate off at the next cycle
  p_oc_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> (gate_hi == '0 && gate_lo == '0));

  // R10: the blanking latch is held until a period start
  p_oc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latch_q && !period_start) |=> oc_latch_q);

  // R11: a sampled hall error turns every gate off at the next cycle
  p_hall_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hall_err |=> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/pwm3_engine_bench.sv
module pwm3_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV  = 6;
  localparam int NPER = 4;

  // stimulus: mode, period, per-phase duty, dead time; expected per-period gate cycles
  localparam int T_MODE [NV]    = '{0, 0, 1, 2, 3, 0};
  localparam int T_PER  [NV]    = '{9, 7, 9, 8, 6, 15};
  localparam int T_LEN  [NV]    = '{10, 8, 10, 16, 12, 16};
  localparam int T_DT   [NV]    = '{1, 0, 2, 1, 2, 3};
  localparam int T_DUTY [NV][3] = '{'{3,5,10}, '{0,4,2}, '{3,6,1}, '{3,5,9}, '{6,1,2}, '{8,12,4}};
  localparam int T_HI   [NV][3] = '{'{2,4,10}, '{0,4,2}, '{1,4,0}, '{4,8,16}, '{9,0,1}, '{5,9,1}};
  localparam int T_LO   [NV][3] = '{'{6,4,0}, '{8,4,6}, '{5,2,7}, '{10,6,0}, '{0,9,7}, '{5,1,9}};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       oc_high = 1'b0, oc_low = 1'b0, hall_err = 1'b0;
  logic [2:0] gate_hi, gate_lo;
  logic       peak_stb, valley_stb;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm3_engine u_pwm3_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oc_high(oc_high), .oc_low(oc_low), .hall_err(hall_err),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .peak_stb(peak_stb), .valley_stb(valley_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_duty(input int p, input int d);
    wr(4 + 2*p, (d >> 3) & 8'hff);
    wr(5 + 2*p, d & 7);
  endtask

  task automatic set_period(input int p);
    wr(2, p & 8'hff);
    wr(3, (p >> 8) & 8'hff);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_peak();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!peak_stb && guard < 2000);
  endtask

  task automatic wait_valley();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!valley_stb && guard < 2000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int hi_c [3];
    int lo_c [3];
    int both_c, pk_c, va_c, joint_c, s0, s1, s2;

    // R1: reset state
    idle(3);
    chk("R1 outputs in reset", {gate_hi, gate_lo, peak_stb, valley_stb}, 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 default low sides", gate_lo, 7);
    chk("R1 default high sides", gate_hi, 0);

    // table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < NV; v++) begin
      set_period(T_PER[v]);
      for (int p = 0; p < 3; p++) begin
        set_duty(p, T_DUTY[v][p]);
        wr(10 + p, T_DT[v]);
      end
      wr(0, T_MODE[v]);
      idle(100);
      foreach (hi_c[p]) begin hi_c[p] = 0; lo_c[p] = 0; end
      both_c = 0; pk_c = 0; va_c = 0; joint_c = 0;
      for (int c = 0; c < NPER * T_LEN[v]; c++) begin
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
          hi_c[p] += int'(gate_hi[p]);
          lo_c[p] += int'(gate_lo[p]);
          both_c  += int'(gate_hi[p] & gate_lo[p]);
        end
        pk_c    += int'(peak_stb);
        va_c    += int'(valley_stb);
        joint_c += int'(peak_stb & valley_stb);
      end
      for (int p = 0; p < 3; p++) begin
        chk($sformatf("R6 R7 vec%0d ph%0d high cycles", v, p), hi_c[p], NPER * T_HI[v][p]);
        chk($sformatf("R6 R7 vec%0d ph%0d low cycles", v, p), lo_c[p], NPER * T_LO[v][p]);
      end
      chk($sformatf("R7 vec%0d overlap", v), both_c, 0);
      chk($sformatf("R2 R3 R4 vec%0d peaks", v), pk_c, NPER);
      chk($sformatf("R2 R3 R4 vec%0d valleys", v), va_c, NPER);
      chk($sformatf("R2 R3 R4 vec%0d joint strobes", v), joint_c,
          (T_MODE[v] >= 2) ? 0 : NPER);
    end

    // R4: valley to peak spacing
    wr(0, 2); set_period(5);
    idle(60);
    wait_valley(); s0 = cyc;
    wait_peak();   s1 = cyc;
    chk("R4 valley to peak", s1 - s0, 5);

    // R5: prescaler
    wr(0, 0); set_period(3); wr(1, 2);
    idle(100);
    wait_peak(); s0 = cyc;
    wait_peak(); s1 = cyc;
    chk("R5 prescaled period", s1 - s0, 12);
    wr(1, 0);

    // R8: shadowed duty and period
    set_period(19);
    for (int p = 0; p < 3; p++) begin set_duty(p, 10); wr(10 + p, 0); end
    idle(100);
    wait_peak(); s0 = cyc;
    set_duty(0, 2);
    set_period(9);
    idle(2);
    chk("R8 old duty kept", gate_hi[0], 1);
    wait_peak(); s1 = cyc;
    chk("R8 old period kept", s1 - s0, 20);
    wait_peak(); s2 = cyc;
    chk("R8 new period", s2 - s1, 10);
    hi_c[0] = 0;
    for (int c = 0; c < 10; c++) begin @(negedge clk); hi_c[0] += int'(gate_hi[0]); end
    chk("R8 R6 new duty width", hi_c[0], 2);

    // R9 R10: over-current high
    wait_peak();
    idle(2);
    oc_high = 1'b1;
    @(negedge clk);
    oc_high = 1'b0;
    chk("R9 oc_high blanks", {gate_hi, gate_lo}, 0);
    idle(3);
    chk("R10 held mid-period", {gate_hi, gate_lo}, 0);
    wait_peak();
    chk("R10 released at period start", gate_hi | gate_lo, 7);

    // R9: over-current low, held across a period start
    idle(2);
    oc_low = 1'b1;
    @(negedge clk);
    chk("R9 oc_low blanks", {gate_hi, gate_lo}, 0);
    wait_peak();
    chk("R9 flag at period start keeps blank", {gate_hi, gate_lo}, 0);
    oc_low = 1'b0;
    idle(2);
    chk("R10 still held after flag drop", {gate_hi, gate_lo}, 0);
    wait_peak();
    chk("R10 released after flag drop", gate_hi | gate_lo, 7);

    // R11: hall error
    idle(3);
    hall_err = 1'b1;
    @(negedge clk);
    chk("R11 hall blanks", {gate_hi, gate_lo}, 0);
    both_c = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      both_c += int'(gate_hi != 0) + int'(gate_lo != 0);
    end
    chk("R11 held across period start", both_c, 0);
    hall_err = 1'b0;
    @(negedge clk);
    chk("R11 immediate release", gate_hi | gate_lo, 7);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule